// File: doc/BRIEF.md
# Wide Store Beat Sequencer

This block turns one store instruction into a series of 32-bit writes on a memory port that is one word wide. A plain word store needs one write. A doubleword store needs two. A quadword store needs four. The pipeline gives the block a store kind, an effective address and the low 32 bits of the source register. Only that low word carries data. The register bits above it are not modelled, so every write after the first puts zero into memory.

Each kind has its own alignment rule. A store that breaks its rule writes nothing and raises a one-cycle address-error pulse on the path a misaligned word store would take. An accepted store keeps `busy` high and stalls retirement until memory has acknowledged the last write. The block then raises a single `done` pulse. Requests that arrive while `busy` is high are dropped.

Top module: `wide_store_seq`

## Requirements
- R1: `req_kind` selects the store: 2'b00 is a word store (1 beat), 2'b01 is a doubleword store (2 beats), 2'b10 is a quadword store (4 beats).
- R2: The alignment rules are addr[1:0]==0 for a word store, addr[2:0]==0 for a doubleword store and addr[3:0]==0 for a quadword store. A request that breaks its rule pulses `addr_err` for exactly one cycle, in the cycle after the request. It issues no write and leaves `busy` low.
- R3: Beat 0 writes `req_data` at the request address.
- R4: Beat k (k >= 1) writes zero at the request address plus 4*k.
- R5: A beat holds `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack` is seen high at a clock edge. The next beat starts in the following cycle.
- R6: `busy` and `mem_we` go high in the cycle after an aligned request is taken. They stay high until the clock edge that samples the last acknowledge. In the cycle after that edge, `busy` is low and `done` is high for exactly one cycle.
- R7: `req_valid` is ignored while `busy` is high. No second store starts and no error is raised.
- R8: `req_kind` 2'b11 is ignored. It causes no beats, no busy and no error.
- R9: After reset, `busy`, `mem_we`, `done` and `addr_err` are low.
- R10: Every word a store writes is fully overwritten, so no earlier memory content survives in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request strobe, taken when not busy |
| req_kind | input | 2 | Store kind (see R1) |
| req_addr | input | AW | Effective address |
| req_data | input | 32 | Low word of the source register |
| busy | output | 1 | Sequence in progress; stalls retirement |
| done | output | 1 | One-cycle retire pulse after the last beat |
| addr_err | output | 1 | One-cycle address-error-on-store pulse |
| mem_we | output | 1 | Write beat valid |
| mem_addr | output | AW | Word address of the current beat |
| mem_wdata | output | 32 | Data of the current beat |
| mem_ack | input | 1 | Memory accepts the current beat |

## Verification
The bench fills memory with non-zero junk first, so a design that skipped a beat or wrote stale data into an upper word would leave junk behind. It also catches a design that repeated the source word instead of writing zero. Acknowledges come in an irregular pattern. A design that advanced a beat without an acknowledge, or changed address or data during a stall, would break the per-cycle comparison. Each misalignment case is aimed at the bit just inside each kind's rule. Examples are an address ending in 4 for a doubleword store and one ending in 8 for a quadword store, which a design checking too few bits would accept. Requests are also made during a busy sequence and with the reserved kind, to show that neither causes a write.

// File: rtl/wide_store_seq.sv
module wide_store_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  output logic          busy,
  output logic          done,
  output logic          addr_err,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack
);
  logic          active;
  logic [1:0]    beat, last;
  logic [AW-1:0] base;
  logic [31:0]   data;
  logic          aligned, legal;

  assign legal = req_kind != 2'b11;

  always_comb begin
    case (req_kind)
      2'b00:   aligned = req_addr[1:0] == 2'b00;
      2'b01:   aligned = req_addr[2:0] == 3'b000;
      default: aligned = req_addr[3:0] == 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat     <= '0;
      last     <= '0;
      base     <= '0;
      data     <= '0;
      done     <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      addr_err <= 1'b0;
      if (!active) begin
        if (req_valid && legal) begin
          if (aligned) begin
            active <= 1'b1;
            beat   <= '0;
            base   <= req_addr;
            data   <= req_data;
            case (req_kind)
              2'b00:   last <= 2'd0;
              2'b01:   last <= 2'd1;
              default: last <= 2'd3;
            endcase
          end else begin
            addr_err <= 1'b1;
          end
        end
      end else if (mem_ack) begin
        if (beat == last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          beat <= beat + 2'd1;
        end
      end
    end
  end

  assign busy      = active;
  assign mem_we    = active;
  assign mem_addr  = base + AW'({beat, 2'b00});
  assign mem_wdata = (beat == 2'd0) ? data : 32'd0;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(mem_we && mem_ack));
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_ack |=> mem_we && $stable(mem_addr) && $stable(mem_wdata));
  // R4
  later_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we && mem_ack) |-> mem_wdata == 32'd0);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we && mem_ack) |-> mem_addr == $past(mem_addr) + AW'(4));
  // R2
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !mem_we && !busy);
endmodule

// File: tb/sim_wide_store_seq.sv
module sim_wide_store_seq;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_data = 0;
  logic busy, done, addr_err, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic ack_en = 1;
  logic [7:0] lfsr = 8'hA5;
  logic ack_rand = 0;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [64];
  logic [31:0] exp_mem [64];

  bit m_busy = 0, m_done = 0, m_err = 0;
  int m_beat = 0, m_n = 0;
  logic [AW-1:0] m_base = 0;
  logic [31:0] m_data = 0;

  always #4 clk = ~clk;

  wide_store_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .addr_err(addr_err), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack));

  assign mem_ack = mem_we && (ack_rand ? lfsr[0] : ack_en);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic bit is_aligned(input logic [1:0] k, input logic [AW-1:0] a);
    int al = (k == 0) ? 4 : (k == 1) ? 8 : 16;
    return (a % al) == 0;
  endfunction

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    cycles++;
    if (mem_we && mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_beat = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (!m_busy) begin
        if (req_valid && req_kind != 2'b11) begin
          if (is_aligned(req_kind, req_addr)) begin
            m_busy = 1; m_beat = 0; m_base = req_addr; m_data = req_data;
            m_n = 1 << req_kind;
          end else m_err = 1;
        end
      end else if (mem_ack) begin
        if (m_beat == m_n - 1) begin m_busy = 0; m_done = 1; end
        else m_beat++;
      end
    end
    #2;
    if (rst_n) begin
      chk(busy == m_busy, "R6 busy", 64'(busy), 64'(m_busy));
      chk(mem_we == m_busy, "R6 mem_we", 64'(mem_we), 64'(m_busy));
      chk(done == m_done, "R6 done", 64'(done), 64'(m_done));
      chk(addr_err == m_err, "R2 addr_err", 64'(addr_err), 64'(m_err));
      if (m_busy) begin
        chk(mem_addr == m_base + AW'(4 * m_beat), "R4 mem_addr", 64'(mem_addr), 64'(m_base + AW'(4 * m_beat)));
        chk(mem_wdata == ((m_beat == 0) ? m_data : 32'd0), "R3 mem_wdata",
            64'(mem_wdata), 64'((m_beat == 0) ? m_data : 32'd0));
      end
    end
  end

  task automatic mem_check(input string req);
    for (int i = 0; i < 64; i++)
      chk(mem[i] === exp_mem[i], req, 64'(mem[i]), 64'(exp_mem[i]));
  endtask

  task automatic store(input logic [1:0] k, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_data = d;
    if (k != 2'b11 && is_aligned(k, a))
      for (int b = 0; b < (1 << k); b++)
        exp_mem[(a[7:2] + b) % 64] = (b == 0) ? d : 32'd0;
    @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'hDEAD_0000 | 32'(i) | 32'h0100_0000;
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !mem_we && !done && !addr_err, "R9 reset",
        64'({busy, mem_we, done, addr_err}), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R4 R10 all kinds, ack always
    store(2'b00, 32'h04, 32'h1111_2222); mem_check("R1 word store memory");
    store(2'b01, 32'h08, 32'h3333_4444); mem_check("R3 doubleword memory");
    store(2'b10, 32'h20, 32'h5555_6666); mem_check("R4 quadword memory");
    // R5 stalled acks
    ack_rand = 1;
    store(2'b10, 32'h40, 32'hCAFE_BABE); mem_check("R10 quadword stalled");
    store(2'b01, 32'h78, 32'h0BAD_F00D); mem_check("R5 doubleword stalled");
    store(2'b00, 32'h9C, 32'h7777_8888); mem_check("R5 word stalled");
    ack_rand = 0;
    // R2 misaligned on boundary bits
    store(2'b01, 32'h0C, 32'hAAAA_0001); mem_check("R2 doubleword addr ends 4");
    store(2'b10, 32'h58, 32'hAAAA_0002); mem_check("R2 quadword addr ends 8");
    store(2'b10, 32'h64, 32'hAAAA_0003); mem_check("R2 quadword addr ends 4");
    store(2'b00, 32'h11, 32'hAAAA_0004); mem_check("R2 word addr ends 1");
    // R8 reserved kind
    store(2'b11, 32'hC0, 32'hAAAA_0005); mem_check("R8 reserved kind");
    // R7 request while busy is dropped
    ack_en = 0;
    @(negedge clk);
    req_valid = 1; req_kind = 2'b10; req_addr = 32'hE0; req_data = 32'h1234_5678;
    for (int b = 0; b < 4; b++) exp_mem[56 + b] = (b == 0) ? 32'h1234_5678 : 32'd0;
    @(negedge clk);
    req_kind = 2'b01; req_addr = 32'hD0; req_data = 32'h9999_9999;
    repeat (3) @(negedge clk);
    req_valid = 0; ack_en = 1;
    while (busy) @(negedge clk);
    @(negedge clk);
    mem_check("R7 request while busy");
    ack_en = 1;
    store(2'b01, 32'hF8, 32'hFEED_0001); mem_check("R10 final doubleword");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule